// File: doc/BRIEF.md
# Event Queue with Occupancy Monitor

This block is a sixteen-slot circular queue for transfer-request events. A producer pushes event words at the tail, and a consumer takes the word at the head. The head word is always visible on the pop output without any delay. Alongside the storage, the block keeps live figures on how the queue is used, and packs them into one read-only 32-bit status word that software can sample.

The status word reports four things: the number of entries held, the head slot offset, and the highest occupancy reached since reset or since the last clear. It also carries a sticky alarm. The alarm latches when occupancy rises above a programmable limit. A single write-one-to-clear input drops the alarm and restarts the peak tracking. A push into a full queue is dropped and is reported by a one-cycle overflow pulse.

Top module: `evq_monitor`

## Requirements
- R1: The entry count is reported in status bits 12:8 and ranges from 0 to 16. A push is accepted only while the count is below 16, and a pop only while it is above 0. The count shows the result one clock after the request.
- R2: A push and a pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged and advance the head by one.
- R3: Status bits 3:0 hold the head slot. The head advances by one on each accepted pop and wraps from 15 to 0. `pop_data` presents the head entry combinationally, and entries leave in the order they were pushed.
- R4: Status bits 20:16 hold the peak: the largest count reached since reset or since the last clear. It never reads below the live count.
- R5: Status bit 24 sets when the count after the update is strictly greater than `thresh`. It stays set until it is cleared.
- R6: `clr` = 1 clears the alarm and loads the peak with the count after that cycle's update. `clr` = 0 changes nothing.
- R7: When a clear and a threshold crossing fall in the same cycle, the set wins and the alarm stays 1.
- R8: A push to a full queue is ignored and raises `ovf` in that same cycle. A pop from an empty queue is ignored, and the count and the head stay unchanged.
- R9: After reset, all status fields are 0. Status bits 31:25, 23:21, 15:13 and 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| push | input | 1 | Push request |
| push_data | input | DW | Event word to enqueue |
| pop | input | 1 | Pop request |
| pop_data | output | DW | Head entry, combinational |
| thresh | input | 5 | Occupancy alarm limit |
| clr | input | 1 | Write-one-to-clear for the alarm and the peak |
| status | output | 32 | Packed status word |
| ovf | output | 1 | Rejected-push pulse |

## Verification
The two functions that can meet in one cycle are the alarm clear and a new threshold crossing. Peak reload and peak growth can also coincide under a clear.

The bench provokes these cases in two ways:
- A directed step pulses `clr` together with a push that lifts the count above `thresh`.
- The random phase asserts `clr` together with random pushes, pops and limits.

A bench model judges every step. It applies the rule that the set wins, and that the peak reloads to the count after the update. The model is compared with the alarm bit and the peak field one clock later.

// File: rtl/evq_monitor.sv
module evq_monitor #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  input  logic [4:0]    thresh,
  input  logic          clr,
  output logic [31:0]   status,
  output logic          ovf
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count, peak, count_nx;
  logic          alarm;

  wire full     = (count == CW'(DEPTH));
  wire empty    = (count == '0);
  wire acc_push = push & ~full;
  wire acc_pop  = pop & ~empty;
  wire over     = ({{(8-CW){1'b0}}, count_nx} > {3'b000, thresh});

  assign count_nx = count + CW'(acc_push) - CW'(acc_pop);
  assign pop_data = mem[head];
  assign ovf      = push & full;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (acc_push) mem[tail] <= push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      peak  <= '0;
      alarm <= 1'b0;
    end else begin
      if (acc_push) tail <= wrap_inc(tail);
      if (acc_pop)  head <= wrap_inc(head);
      count <= count_nx;
      if (clr || count_nx > peak) peak <= count_nx;
      if (over)     alarm <= 1'b1;
      else if (clr) alarm <= 1'b0;
    end
  end

  always_comb begin
    status            = '0;
    status[24]        = alarm;
    status[16 +: CW]  = peak;
    status[8 +: CW]   = count;
    status[0 +: PW]   = head;
  end
endmodule

// File: rtl/evq_monitor_chk.sv
module evq_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        push,
  input logic        pop,
  input logic        clr,
  input logic        ovf,
  input logic [31:0] status
);
  wire [4:0] cnt = status[12:8];
  wire [4:0] pk  = status[20:16];
  wire [3:0] hd  = status[3:0];
  wire       flg = status[24];

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= 5'd16); // R1
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n) (pop && cnt != 0) |=> hd == $past(hd) + 4'd1); // R3
  AST_PEAK_GE_COUNT: assert property (@(posedge clk) disable iff (!rst_n) pk >= cnt); // R4
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flg && !clr) |=> flg); // R5
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> (push && cnt == 5'd16)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 5'd16 && push && !pop) |=> cnt == 5'd16); // R8
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt == 0 && pop && !push) |=> (cnt == 0 && $stable(hd))); // R8
endmodule

bind evq_monitor evq_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
  .clr(clr), .ovf(ovf), .status(status)
);

// File: tb/evq_monitor_tb.sv
module evq_monitor_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        push = 0, pop = 0, clr = 0;
  logic [31:0] push_data = 0;
  logic [4:0]  thresh = 5'd31;
  logic [31:0] pop_data, status;
  logic        ovf;

  int checks = 0, errors = 0;

  logic [31:0] mq [16];
  int mhead = 0, mcnt = 0, mpk = 0;
  logic mflag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evq_monitor dut_i (.clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop(pop), .pop_data(pop_data), .thresh(thresh), .clr(clr),
    .status(status), .ovf(ovf));

  task automatic chk(input string tag, input string ctx, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {7'd0, mflag, 3'd0, 5'(mpk), 3'd0, 5'(mcnt), 4'd0, 4'(mhead)};
  endfunction

  task automatic step(input logic pu, input logic [31:0] d, input logic po,
                      input logic cl, input logic [4:0] th, input string ctx);
    logic ap, apo;
    push = pu; push_data = d; pop = po; clr = cl; thresh = th;
    #1;
    chk("R8", ctx, {31'd0, ovf}, {31'd0, pu && mcnt == 16});
    if (mcnt > 0) chk("R3", ctx, pop_data, mq[mhead]);
    @(posedge clk);
    ap  = pu && mcnt < 16;
    apo = po && mcnt > 0;
    if (ap) mq[(mhead + mcnt) % 16] = d;
    if (apo) mhead = (mhead + 1) % 16;
    mcnt = mcnt + int'(ap) - int'(apo);
    if (cl || mcnt > mpk) mpk = mcnt;
    if (mcnt > int'(th)) mflag = 1;
    else if (cl) mflag = 0;
    @(negedge clk);
    chk("R1", ctx, {27'd0, status[12:8]}, 32'(mcnt));
    chk("R3", ctx, {28'd0, status[3:0]}, 32'(mhead));
    chk("R4", ctx, {27'd0, status[20:16]}, 32'(mpk));
    chk("R5", ctx, {31'd0, status[24]}, {31'd0, mflag});
    chk("R9", ctx, status & 32'hFEE0_E0F0, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R9", "reset", status, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R9", "after reset", status, 32'd0);

    step(0, 0, 1, 0, 5'd31, "R8 pop empty");
    for (int i = 0; i < 16; i++) step(1, 32'hA000 + i, 0, 0, 5'd10, "fill");
    chk("R5", "alarm above 10", {31'd0, status[24]}, 32'd1);
    step(1, 32'hDEAD, 0, 0, 5'd10, "R8 push full");
    step(1, 32'hBEEF, 1, 0, 5'd31, "R8 full push+pop");
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 5'd31, "drain");
    step(1, 32'h1234, 1, 0, 5'd31, "R2 push+pop");
    chk("R2", "count held", {27'd0, status[12:8]}, 32'd10);
    step(0, 0, 0, 1, 5'd31, "R6 clear");
    chk("R6", "alarm cleared", {31'd0, status[24]}, 32'd0);
    chk("R6", "peak reload", {27'd0, status[20:16]}, 32'd10);
    step(0, 0, 0, 0, 5'd31, "R6 clr low");
    chk("R6", "no effect", {27'd0, status[20:16]}, 32'd10);
    step(1, 32'h77, 0, 1, 5'd10, "R7 set wins");
    chk("R7", "alarm kept", {31'd0, status[24]}, 32'd1);
    for (int i = 0; i < 11; i++) step(0, 0, 1, 0, 5'd31, "wrap");

    for (int i = 0; i < 3000; i++)
      step(($urandom % 100) < 55, $urandom, ($urandom % 100) < 45,
           ($urandom % 8) == 0, 5'($urandom % 17), "random");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule